// File: doc/BRIEF.md
# Ethernet PHY Bring-Up and Link Sequencer

This block brings an Ethernet PHY from an unknown state to a usable link. It does this through a separate serial management master that carries out register reads and writes. A pulse on `start` launches a fixed series of management accesses:

- a soft reset of the PHY, followed by polling until that reset has finished;
- publication of the 10 Mb and 100 Mb abilities;
- a restart of autonegotiation, followed by polling until it completes;
- one last status read, from which the sequencer decides the line rate and the duplex mode.

Each poll is limited to a fixed number of reads. Between two reads the sequencer waits a programmable number of clocks. If a poll never reaches its exit condition, the run ends with an error flag instead of a link.

The management master is driven by a level request. While the request is high, the access fields (write flag, PHY address, register number, write data) are held steady. The master ends the access with a one-cycle done pulse, and for reads it supplies the register value in that same cycle. The results and error flags keep their values until the next `start`.

Top module: `phy_link_seq`

## Requirements
- R1: After reset, `busy`, `linkUp`, `speed100`, `fullDuplex`, `errResetTimeout`, `errAnegTimeout` and `mgmtReq` are all low.
- R2: The first access after `start` is a write (`mgmtWrite`=1) of 0x8000 (bit 15, soft reset) to register 0. Every access of the run uses the PHY address sampled from `phyAddr` in the cycle that `start` was taken.
- R3: Register 0 is then read (`mgmtWrite`=0) until bit 15 reads 0, for at most RESET_POLLS reads. Between a failed read and the next read, `mgmtReq` stays low for exactly WAIT_CLKS cycles.
- R4: If bit 15 is still set on read number RESET_POLLS, `errResetTimeout` rises, `busy` falls, `linkUp` stays low and no further access is issued.
- R5: Once the reset has cleared, register 4 is written with 0x01E1. That value sets bits 8..5 (100 full, 100 half, 10 full, 10 half) and selector 00001. Register 0 is then written with 0x1200 (bit 12 autonegotiation enable, bit 9 restart). These accesses follow one another with no idle cycle.
- R6: Register 1 is then read until bit 5 (autonegotiation complete) is set, for at most ANEG_POLLS reads. Between a failed read and the next read there is the same WAIT_CLKS gap.
- R7: If bit 5 is still clear on read number ANEG_POLLS, `errAnegTimeout` rises, `busy` falls, `linkUp` stays low and no further access is issued.
- R8: After completion, one more read of register 1 follows directly. `speed100` is set when bit 14 (100 full) or bit 13 (100 half) of that value is 1.
- R9: `fullDuplex` is set when bit 14 (100 full) or bit 12 (10 full) of that final value is 1.
- R10: On success `linkUp` rises as `busy` falls. Results and error flags hold until the next accepted `start`, which clears all of them in the cycle after it is taken.
- R11: A `start` pulse while `busy` is high has no effect: the access list and the outcome are unchanged.
- R12: Once raised, `mgmtReq` stays high with stable fields until `mgmtDone` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run (taken only when idle) |
| phyAddr | input | 5 | PHY address for the run |
| mgmtReq | output | 1 | Access request to the management master |
| mgmtWrite | output | 1 | 1 = write access, 0 = read access |
| mgmtPhyAddr | output | 5 | PHY address of the access |
| mgmtRegAddr | output | 5 | Register number of the access |
| mgmtWrData | output | 16 | Write data |
| mgmtRdData | input | 16 | Read data, valid with mgmtDone |
| mgmtDone | input | 1 | One-cycle access completion |
| busy | output | 1 | Run in progress |
| linkUp | output | 1 | Run finished successfully |
| speed100 | output | 1 | Resolved rate: 1 = 100 Mb, 0 = 10 Mb |
| fullDuplex | output | 1 | Resolved duplex: 1 = full |
| errResetTimeout | output | 1 | PHY reset never finished |
| errAnegTimeout | output | 1 | Autonegotiation never finished |

## Verification
The bench plays the management master and the PHY. It measures the idle gap before every access, so a design that skips the wait, or waits one clock too long or too short, shows up as a gap mismatch. Both polls are tested exactly at their limits: a reset that clears on the tenth read, and autonegotiation that completes on the hundredth read, must succeed. One poll more must give the matching error with no further access; an off-by-one bound would either time out early or issue an extra read. The abilities are tried one at a time and in the mixed case of 100 half with 10 full, which must resolve to 100 Mb full duplex. A design that took duplex from the 100 Mb bits alone would report half duplex there. A mid-run `start` must leave the access list intact; a design that restarts on it would repeat the soft-reset write.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam logic [4:0]  REG_CTRL = 5'd0;
  localparam logic [4:0]  REG_STAT = 5'd1;
  localparam logic [4:0]  REG_ADV  = 5'd4;

  localparam logic [15:0] CTRL_SOFT_RESET = 16'h8000;
  localparam logic [15:0] CTRL_ANEG_GO    = 16'h1200;
  localparam logic [15:0] ADV_ALL_10_100  = 16'h01E1;

  localparam int CTRL_RST_BIT  = 15;
  localparam int STAT_DONE_BIT = 5;
  localparam int STAT_100F_BIT = 14;
  localparam int STAT_100H_BIT = 13;
  localparam int STAT_10F_BIT  = 12;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_WR_RST,
    ACC_RD_CTRL,
    ACC_WR_ADV,
    ACC_WR_ANEG,
    ACC_RD_STAT
  } mgmtAcc_t;

  typedef struct packed {
    logic clrAll;
    logic pollClr;
    logic pollInc;
    logic waitLoad;
    logic setResult;
    logic setErrRst;
    logic setErrAneg;
  } seqStrobe_t;

endpackage

// File: rtl/phy_seq_dp.sv
module phy_seq_dp
  import phy_seq_pkg::*;
#(
  parameter int WAIT_CLKS   = 2500000,
  parameter int RESET_POLLS = 10,
  parameter int ANEG_POLLS  = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  strb,
  input  mgmtAcc_t    acc,
  input  logic [4:0]  phyAddrIn,
  input  logic [15:0] rdData,
  output logic        mgmtReq,
  output logic        mgmtWrite,
  output logic [4:0]  mgmtPhyAddr,
  output logic [4:0]  mgmtRegAddr,
  output logic [15:0] mgmtWrData,
  output logic        waitDone,
  output logic        pollLast,
  output logic        linkUp,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        errRst,
  output logic        errAneg
);

  localparam int MAXP = (RESET_POLLS > ANEG_POLLS) ? RESET_POLLS : ANEG_POLLS;
  localparam int PW   = $clog2(MAXP + 1);
  localparam int WW   = $clog2(WAIT_CLKS + 1);

  logic [PW-1:0] pollCnt;
  logic [WW-1:0] waitCnt;
  logic [4:0]    addrLatch;

  // access field decode
  always_comb begin
    mgmtReq     = (acc != ACC_NONE);
    mgmtWrite   = 1'b0;
    mgmtRegAddr = REG_CTRL;
    mgmtWrData  = '0;
    unique case (acc)
      ACC_WR_RST:  begin mgmtWrite = 1'b1; mgmtWrData = CTRL_SOFT_RESET; end
      ACC_RD_CTRL: mgmtRegAddr = REG_CTRL;
      ACC_WR_ADV:  begin mgmtWrite = 1'b1; mgmtRegAddr = REG_ADV; mgmtWrData = ADV_ALL_10_100; end
      ACC_WR_ANEG: begin mgmtWrite = 1'b1; mgmtWrData = CTRL_ANEG_GO; end
      ACC_RD_STAT: mgmtRegAddr = REG_STAT;
      default:     ;
    endcase
  end
  assign mgmtPhyAddr = addrLatch;

  always_ff @(posedge clk) begin
    if (!rstN) addrLatch <= '0;
    else if (strb.clrAll) addrLatch <= phyAddrIn;
  end

  // poll counter
  always_ff @(posedge clk) begin
    if (!rstN || strb.pollClr) pollCnt <= '0;
    else if (strb.pollInc)     pollCnt <= pollCnt + 1'b1;
  end

  assign pollLast = (acc == ACC_RD_CTRL) ? (pollCnt == PW'(RESET_POLLS - 1))
                                         : (pollCnt == PW'(ANEG_POLLS - 1));

  // wait counter
  always_ff @(posedge clk) begin
    if (!rstN)                waitCnt <= '0;
    else if (strb.waitLoad)   waitCnt <= WW'(WAIT_CLKS - 1);
    else if (waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end
  assign waitDone = (waitCnt == '0);

  // results and errors
  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) begin
      linkUp     <= 1'b0;
      speed100   <= 1'b0;
      fullDuplex <= 1'b0;
      errRst     <= 1'b0;
      errAneg    <= 1'b0;
    end else begin
      if (strb.setResult) begin
        linkUp     <= 1'b1;
        speed100   <= rdData[STAT_100F_BIT] | rdData[STAT_100H_BIT];
        fullDuplex <= rdData[STAT_100F_BIT] | rdData[STAT_10F_BIT];
      end
      if (strb.setErrRst)  errRst  <= 1'b1;
      if (strb.setErrAneg) errAneg <= 1'b1;
    end
  end

  // R3 R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PW'(MAXP));

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mgmtDone,
  input  logic [15:0] rdData,
  input  logic        waitDone,
  input  logic        pollLast,
  output mgmtAcc_t    acc,
  output seqStrobe_t  strb,
  output logic        busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_WR_RST, S_RD_CTRL, S_WAIT_RST, S_WR_ADV,
    S_WR_ANEG, S_RD_STAT, S_WAIT_ANEG, S_RD_FINAL
  } seqState_t;

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    acc       = ACC_NONE;
    unique case (state)
      S_IDLE: if (start) begin
        strb.clrAll  = 1'b1;
        strb.pollClr = 1'b1;
        nextState    = S_WR_RST;
      end
      S_WR_RST: begin
        acc = ACC_WR_RST;
        if (mgmtDone) nextState = S_RD_CTRL;
      end
      S_RD_CTRL: begin
        acc = ACC_RD_CTRL;
        if (mgmtDone) begin
          if (!rdData[CTRL_RST_BIT]) nextState = S_WR_ADV;
          else if (pollLast) begin
            strb.setErrRst = 1'b1;
            nextState      = S_IDLE;
          end else begin
            strb.pollInc  = 1'b1;
            strb.waitLoad = 1'b1;
            nextState     = S_WAIT_RST;
          end
        end
      end
      S_WAIT_RST: if (waitDone) nextState = S_RD_CTRL;
      S_WR_ADV: begin
        acc = ACC_WR_ADV;
        if (mgmtDone) nextState = S_WR_ANEG;
      end
      S_WR_ANEG: begin
        acc = ACC_WR_ANEG;
        if (mgmtDone) begin
          strb.pollClr = 1'b1;
          nextState    = S_RD_STAT;
        end
      end
      S_RD_STAT: begin
        acc = ACC_RD_STAT;
        if (mgmtDone) begin
          if (rdData[STAT_DONE_BIT]) nextState = S_RD_FINAL;
          else if (pollLast) begin
            strb.setErrAneg = 1'b1;
            nextState       = S_IDLE;
          end else begin
            strb.pollInc  = 1'b1;
            strb.waitLoad = 1'b1;
            nextState     = S_WAIT_ANEG;
          end
        end
      end
      S_WAIT_ANEG: if (waitDone) nextState = S_RD_STAT;
      S_RD_FINAL: begin
        acc = ACC_RD_STAT;
        if (mgmtDone) begin
          strb.setResult = 1'b1;
          nextState      = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc != ACC_NONE && !mgmtDone) |=> (acc == $past(acc)));

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !mgmtDone) |=> busy);

endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_seq_pkg::*;
#(
  parameter int WAIT_CLKS   = 2500000,
  parameter int RESET_POLLS = 10,
  parameter int ANEG_POLLS  = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [4:0]  phyAddr,
  output logic        mgmtReq,
  output logic        mgmtWrite,
  output logic [4:0]  mgmtPhyAddr,
  output logic [4:0]  mgmtRegAddr,
  output logic [15:0] mgmtWrData,
  input  logic [15:0] mgmtRdData,
  input  logic        mgmtDone,
  output logic        busy,
  output logic        linkUp,
  output logic        speed100,
  output logic        fullDuplex,
  output logic        errResetTimeout,
  output logic        errAnegTimeout
);

  mgmtAcc_t   acc;
  seqStrobe_t strb;
  logic       waitDone;
  logic       pollLast;

  phy_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .mgmtDone (mgmtDone),
    .rdData   (mgmtRdData),
    .waitDone (waitDone),
    .pollLast (pollLast),
    .acc      (acc),
    .strb     (strb),
    .busy     (busy)
  );

  phy_seq_dp #(
    .WAIT_CLKS   (WAIT_CLKS),
    .RESET_POLLS (RESET_POLLS),
    .ANEG_POLLS  (ANEG_POLLS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .acc         (acc),
    .phyAddrIn   (phyAddr),
    .rdData      (mgmtRdData),
    .mgmtReq     (mgmtReq),
    .mgmtWrite   (mgmtWrite),
    .mgmtPhyAddr (mgmtPhyAddr),
    .mgmtRegAddr (mgmtRegAddr),
    .mgmtWrData  (mgmtWrData),
    .waitDone    (waitDone),
    .pollLast    (pollLast),
    .linkUp      (linkUp),
    .speed100    (speed100),
    .fullDuplex  (fullDuplex),
    .errRst      (errResetTimeout),
    .errAneg     (errAnegTimeout)
  );

  // R10
  link_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> !busy);

  // R4 R7
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({linkUp, errResetTimeout, errAnegTimeout}));

  // R12
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtReq && !mgmtDone) |=> (mgmtReq && $stable(mgmtRegAddr) &&
                                $stable(mgmtWrData) && $stable(mgmtWrite) &&
                                $stable(mgmtPhyAddr)));

endmodule

// File: tb/sim_phy_link_seq.sv
module sim_phy_link_seq;

  localparam int WAIT = 4;
  localparam int LAT  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  phyAddr = '0;
  logic        mgmtReq, mgmtWrite;
  logic [4:0]  mgmtPhyAddr, mgmtRegAddr;
  logic [15:0] mgmtWrData;
  logic [15:0] mgmtRdData = '0;
  logic        mgmtDone = 1'b0;
  logic        busy, linkUp, speed100, fullDuplex, errResetTimeout, errAnegTimeout;

  always #10 clk = ~clk;

  phy_link_seq #(.WAIT_CLKS(WAIT), .RESET_POLLS(10), .ANEG_POLLS(100)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .phyAddr(phyAddr),
    .mgmtReq(mgmtReq), .mgmtWrite(mgmtWrite), .mgmtPhyAddr(mgmtPhyAddr),
    .mgmtRegAddr(mgmtRegAddr), .mgmtWrData(mgmtWrData), .mgmtRdData(mgmtRdData),
    .mgmtDone(mgmtDone), .busy(busy), .linkUp(linkUp), .speed100(speed100),
    .fullDuplex(fullDuplex), .errResetTimeout(errResetTimeout),
    .errAnegTimeout(errAnegTimeout)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  // reference PHY / management master model
  int          nRstCfg, nAnegCfg;
  logic [15:0] abilCfg;
  logic [4:0]  expAddr;
  int          ctrlRd, statRd;
  bit          respBusy = 0;
  int          respCnt, lowCnt = 0;
  int          expQ[$];
  int          gapQ[$];
  string       tagQ[$];
  logic        capW;
  logic [4:0]  capReg, capAddr;
  logic [15:0] capData;

  always @(negedge clk) begin
    if (!rstN) begin
      mgmtDone = 1'b0;
      respBusy = 0;
      lowCnt   = 0;
    end else begin
      if (mgmtDone) begin
        mgmtDone = 1'b0;
        respBusy = 0;
      end
      if (!respBusy) begin
        if (mgmtReq) begin
          capW = mgmtWrite; capReg = mgmtRegAddr; capAddr = mgmtPhyAddr;
          capData = mgmtWrData;
          if (expQ.size() == 0) begin
            chk(0, "R4/R7", "unexpected access", int'({capW, capReg, capData}), 0);
          end else begin
            int e, g;
            string t;
            e = expQ.pop_front(); g = gapQ.pop_front(); t = tagQ.pop_front();
            chk(int'({capW, capReg, capW ? capData : 16'h0}) == e, t, "access",
                int'({capW, capReg, capW ? capData : 16'h0}), e);
            if (g >= 0) chk(lowCnt == g, t, "idle gap", lowCnt, g);
            chk(capAddr == expAddr, "R2", "phy address", capAddr, expAddr);
          end
          respBusy = 1;
          respCnt  = LAT;
          lowCnt   = 0;
        end else begin
          lowCnt++;
        end
      end else begin
        chk(mgmtReq && mgmtRegAddr == capReg && mgmtWrite == capW &&
            mgmtWrData == capData, "R12", "request hold",
            int'({mgmtReq, mgmtRegAddr}), int'({1'b1, capReg}));
        if (respCnt == 0) begin
          mgmtDone = 1'b1;
          if (!capW && capReg == 5'd0) begin
            mgmtRdData = (ctrlRd < nRstCfg) ? 16'hB100 : 16'h3100;
            ctrlRd++;
          end else if (!capW && capReg == 5'd1) begin
            mgmtRdData = (statRd < nAnegCfg) ? (abilCfg | 16'h0004)
                                             : (abilCfg | 16'h0024);
            statRd++;
          end else begin
            mgmtRdData = 16'h0;
          end
        end else begin
          respCnt--;
        end
      end
      if (linkUp && busy) chk(0, "R10", "link while busy", 1, 0);
    end
  end

  task automatic push(bit w, logic [4:0] r, logic [15:0] d, int g, string t);
    expQ.push_back(int'({w, r, d}));
    gapQ.push_back(g);
    tagQ.push_back(t);
  endtask

  task automatic runSeq(int nR, int nA, logic [15:0] abil, logic [4:0] addr, bit midStart);
    int rr, ar;
    bit eRst, eAneg;
    expQ.delete(); gapQ.delete(); tagQ.delete();
    eRst = 0; eAneg = 0;
    push(1, 5'd0, 16'h8000, -1, "R2");
    rr = (nR >= 10) ? 10 : nR + 1;
    for (int i = 0; i < rr; i++) push(0, 5'd0, 16'h0, (i == 0) ? 0 : WAIT, "R3");
    if (nR >= 10) eRst = 1;
    else begin
      push(1, 5'd4, 16'h01E1, 0, "R5");
      push(1, 5'd0, 16'h1200, 0, "R5");
      ar = (nA >= 100) ? 100 : nA + 1;
      for (int i = 0; i < ar; i++) push(0, 5'd1, 16'h0, (i == 0) ? 0 : WAIT, "R6");
      if (nA >= 100) eAneg = 1;
      else push(0, 5'd1, 16'h0, 0, "R8");
    end
    nRstCfg = nR; nAnegCfg = nA; abilCfg = abil; ctrlRd = 0; statRd = 0;
    expAddr = addr; phyAddr = addr;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; phyAddr = ~addr;
    chk(busy && !linkUp && !errResetTimeout && !errAnegTimeout && !speed100 && !fullDuplex,
        "R10", "clear on start", int'({busy, linkUp, errResetTimeout, errAnegTimeout}), 8);
    if (midStart) begin
      repeat (20) @(negedge clk);
      chk(busy, "R11", "busy before second start", busy, 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(expQ.size() == 0, midStart ? "R11" : "R5", "accesses left", expQ.size(), 0);
    chk(errResetTimeout == eRst, "R4", "reset timeout flag", errResetTimeout, eRst);
    chk(errAnegTimeout == eAneg, "R7", "aneg timeout flag", errAnegTimeout, eAneg);
    chk(linkUp == !(eRst || eAneg), "R10", "linkUp", linkUp, !(eRst || eAneg));
    chk(speed100 == (!(eRst || eAneg) && (abil[14] | abil[13])), "R8", "speed100",
        speed100, !(eRst || eAneg) && (abil[14] | abil[13]));
    chk(fullDuplex == (!(eRst || eAneg) && (abil[14] | abil[12])), "R9", "fullDuplex",
        fullDuplex, !(eRst || eAneg) && (abil[14] | abil[12]));
    repeat (12) @(negedge clk);
    chk(!busy && !mgmtReq && linkUp == !(eRst || eAneg), "R10", "outcome held",
        int'({busy, mgmtReq, linkUp}), int'(!(eRst || eAneg)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !linkUp && !speed100 && !fullDuplex && !errResetTimeout &&
        !errAnegTimeout && !mgmtReq, "R1", "reset outputs",
        int'({busy, linkUp, speed100, fullDuplex, errResetTimeout, errAnegTimeout, mgmtReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !mgmtReq, "R1", "idle after reset", int'({busy, mgmtReq}), 0);

    runSeq(2, 3, 16'h7800, 5'h01, 0);     // R8 R9 all abilities
    runSeq(0, 0, 16'h2000, 5'h1F, 0);     // R8 100 half only
    runSeq(1, 0, 16'h1000, 5'h0A, 0);     // R9 10 full only
    runSeq(0, 1, 16'h0800, 5'h00, 0);     // R8 R9 10 half only
    runSeq(0, 0, 16'h3000, 5'h11, 0);     // R9 100 half + 10 full
    runSeq(1000, 0, 16'h7800, 5'h03, 0);  // R4 reset never clears
    runSeq(9, 0, 16'h4000, 5'h04, 0);     // R3 clears on last read
    runSeq(0, 1000, 16'h7800, 5'h05, 0);  // R7 aneg never completes
    runSeq(0, 99, 16'h4000, 5'h06, 0);    // R6 completes on last read
    runSeq(1, 2, 16'h7800, 5'h07, 1);     // R11 start while busy

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule